// File: doc/BRIEF.md
# Video DRAM Start-Up Sequencer

This block sits on the controller side of a dual-port video DRAM and runs the mandatory bring-up sequence after reset. It first waits a settling time given as a count of clock cycles. It then asks a downstream DRAM timing engine for a fixed run of cycles. A group of row-only or refresh-style (CAS-before-RAS) cycles wakes the random-access port. One full transfer-read cycle loads the serial register. A couple of serial clock pulses prime the serial port. A final stop-point-set cycle puts the device into split stop-point addressing.

Each memory cycle is requested with a one-clock pulse on `cycReq`, with a cycle-kind code on `cycType`. The sequencer then holds until the timing engine answers on `cycAck`. After the acknowledge of the stop-point-set cycle, `initDone` rises and stays high until the next reset. From then on the handshake is ignored. A synchronous reset at any moment restarts everything from the settling pause.

Top module: `vram_bringup_seq`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `cycReq` and `initDone` are both low.
- R2: After `rst` falls, `cycReq` stays low for PAUSE_CYCLES-1 clocks and is first high right after the PAUSE_CYCLES-th rising edge with reset low.
- R3: `cycReq` is high for exactly one clock and carries a nonzero `cycType`. No further request appears until an acknowledge has been accepted. The next request appears one clock after the accepted acknowledge.
- R4: The first PORT_INIT_COUNT requests carry code 1 (row-only) when USE_CBR_INIT is 0, and code 2 (CAS-before-RAS) when it is 1.
- R5: The next request is a single full transfer-read, code 3.
- R6: The next SERIAL_PULSES requests are serial clock pulses, code 4.
- R7: The last request is the stop-point-set cycle, code 5. `initDone` stays low until it is acknowledged.
- R8: `initDone` is high from the clock after the stop-point-set acknowledge until reset. While it is high, acknowledges cause no request.
- R9: `cycAck` is accepted only while a request is outstanding, from the clock after the request pulse onward. An acknowledge during the pause, or in the same clock as the request pulse, has no effect.
- R10: A synchronous reset in the middle of the sequence clears `initDone` and `cycReq` and restarts the full pause and cycle order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cycAck | input | 1 | Timing engine acknowledge of the outstanding cycle |
| cycReq | output | 1 | One-clock request pulse for a memory cycle |
| cycType | output | 3 | Cycle-kind code, valid with `cycReq` |
| initDone | output | 1 | Start-up finished, held until reset |

## Verification
The hardest case to reach from the ports is an acknowledge that arrives while no cycle is outstanding. This can happen during the pause, in the same clock as the request pulse, or after completion. A correct responder never produces it. The directed tasks drive `cycAck` into each of these windows on purpose. They then check that the pause length, the gap before the next request and the cycle order are unchanged. A second instance, with the refresh-style option and a shorter pause, runs against an automatic responder so that the other code of the random-port phase is also observed.

// File: rtl/vram_init_pkg.sv
package vram_init_pkg;

  typedef enum logic [2:0] {
    CYC_NONE      = 3'd0,
    CYC_RAS_ONLY  = 3'd1,
    CYC_CBR       = 3'd2,
    CYC_XFER_READ = 3'd3,
    CYC_SER_CLK   = 3'd4,
    CYC_STOP_SET  = 3'd5
  } cyc_kind_e;

  typedef enum logic [1:0] {
    PH_PORT,
    PH_XFER,
    PH_SERIAL,
    PH_STOP
  } phase_e;

  typedef enum logic [1:0] {
    ST_PAUSE,
    ST_ISSUE,
    ST_WAIT,
    ST_DONE
  } seq_state_e;

  typedef struct packed {
    logic pauseInc;
    logic cntInc;
    logic cntClr;
  } seq_strobe_t;

endpackage

// File: rtl/vram_init_datapath.sv
module vram_init_datapath
  import vram_init_pkg::*;
#(
  parameter int PAUSE_CYCLES = 20,
  parameter int PAUSE_W      = 5,
  parameter int CNT_W        = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  seq_strobe_t      strb,
  input  logic [CNT_W-1:0] lastIdx,
  output logic             pauseEnd,
  output logic             cntLast
);

  localparam logic [PAUSE_W-1:0] PauseLast = PAUSE_W'(PAUSE_CYCLES - 1);

  logic [PAUSE_W-1:0] pauseCnt;
  logic [CNT_W-1:0]   cycCnt;

  always_ff @(posedge clk) begin
    if (rst) pauseCnt <= '0;
    else if (strb.pauseInc) pauseCnt <= pauseCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || strb.cntClr) cycCnt <= '0;
    else if (strb.cntInc) cycCnt <= cycCnt + 1'b1;
  end

  assign pauseEnd = (pauseCnt == PauseLast);
  assign cntLast  = (cycCnt == lastIdx);

  AST_PAUSE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    pauseCnt <= PauseLast) else $error("pause counter overran"); // R2

  AST_NO_COUNT_PAST_LAST: assert property (@(posedge clk) disable iff (rst)
    strb.cntInc |-> !cntLast) else $error("cycle counter stepped past limit"); // R4

  AST_PAUSE_FROZEN_AT_END: assert property (@(posedge clk) disable iff (rst)
    pauseEnd |-> !strb.pauseInc) else $error("pause counter kept running"); // R2

endmodule

// File: rtl/vram_init_control.sv
module vram_init_control
  import vram_init_pkg::*;
#(
  parameter int PORT_INIT_COUNT = 8,
  parameter int SERIAL_PULSES   = 2,
  parameter bit USE_CBR_INIT    = 1'b0,
  parameter int CNT_W           = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cycAck,
  input  logic             pauseEnd,
  input  logic             cntLast,
  output seq_strobe_t      strb,
  output logic [CNT_W-1:0] lastIdx,
  output logic             cycReq,
  output logic [2:0]       cycType,
  output logic             initDone
);

  localparam cyc_kind_e PortKind = USE_CBR_INIT ? CYC_CBR : CYC_RAS_ONLY;

  seq_state_e state, stateNext;
  phase_e     phase, phaseNext;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_PAUSE;
      phase <= PH_PORT;
    end else begin
      state <= stateNext;
      phase <= phaseNext;
    end
  end

  always_comb begin
    stateNext = state;
    phaseNext = phase;
    strb      = '0;
    unique case (state)
      ST_PAUSE: begin
        if (pauseEnd) stateNext = ST_ISSUE;
        else strb.pauseInc = 1'b1;
      end
      ST_ISSUE: stateNext = ST_WAIT;
      ST_WAIT: begin
        if (cycAck) begin
          if (cntLast) begin
            strb.cntClr = 1'b1;
            unique case (phase)
              PH_PORT:   begin phaseNext = PH_XFER;   stateNext = ST_ISSUE; end
              PH_XFER:   begin phaseNext = PH_SERIAL; stateNext = ST_ISSUE; end
              PH_SERIAL: begin phaseNext = PH_STOP;   stateNext = ST_ISSUE; end
              default:   stateNext = ST_DONE;
            endcase
          end else begin
            strb.cntInc = 1'b1;
            stateNext   = ST_ISSUE;
          end
        end
      end
      default: stateNext = ST_DONE;
    endcase
  end

  always_comb begin
    unique case (phase)
      PH_PORT:   lastIdx = CNT_W'(PORT_INIT_COUNT - 1);
      PH_SERIAL: lastIdx = CNT_W'(SERIAL_PULSES - 1);
      default:   lastIdx = '0;
    endcase
  end

  always_comb begin
    cyc_kind_e kind;
    unique case (phase)
      PH_PORT:   kind = PortKind;
      PH_XFER:   kind = CYC_XFER_READ;
      PH_SERIAL: kind = CYC_SER_CLK;
      default:   kind = CYC_STOP_SET;
    endcase
    cycType = (state == ST_ISSUE) ? kind : CYC_NONE;
  end

  assign cycReq   = (state == ST_ISSUE);
  assign initDone = (state == ST_DONE);

  AST_REQ_SINGLE_CLOCK: assert property (@(posedge clk) disable iff (rst)
    cycReq |=> !cycReq) else $error("request longer than one clock"); // R3

  AST_REQ_HAS_KIND: assert property (@(posedge clk) disable iff (rst)
    cycReq |-> cycType != 3'd0) else $error("request without kind"); // R3

  AST_DONE_STICKS: assert property (@(posedge clk) disable iff (rst)
    initDone |=> initDone) else $error("done dropped"); // R8

  AST_QUIET_WHEN_DONE: assert property (@(posedge clk) disable iff (rst)
    initDone |-> !cycReq) else $error("request after done"); // R8

  AST_DONE_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
    $rose(initDone) |-> $past(cycAck) && $past(phase == PH_STOP)) else $error("done without stop ack"); // R7

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> !cycReq && !initDone) else $error("reset left outputs active"); // R10

endmodule

// File: rtl/vram_bringup_seq.sv
module vram_bringup_seq
  import vram_init_pkg::*;
#(
  parameter int PAUSE_CYCLES    = 20,
  parameter int PORT_INIT_COUNT = 8,
  parameter int SERIAL_PULSES   = 2,
  parameter bit USE_CBR_INIT    = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cycAck,
  output logic       cycReq,
  output logic [2:0] cycType,
  output logic       initDone
);

  localparam int MaxRun  = (PORT_INIT_COUNT > SERIAL_PULSES) ? PORT_INIT_COUNT : SERIAL_PULSES;
  localparam int CntW    = (MaxRun > 1) ? $clog2(MaxRun) : 1;
  localparam int PauseW  = (PAUSE_CYCLES > 1) ? $clog2(PAUSE_CYCLES) : 1;

  seq_strobe_t     strb;
  logic [CntW-1:0] lastIdx;
  logic            pauseEnd;
  logic            cntLast;

  vram_init_control #(
    .PORT_INIT_COUNT(PORT_INIT_COUNT),
    .SERIAL_PULSES  (SERIAL_PULSES),
    .USE_CBR_INIT   (USE_CBR_INIT),
    .CNT_W          (CntW)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .cycAck  (cycAck),
    .pauseEnd(pauseEnd),
    .cntLast (cntLast),
    .strb    (strb),
    .lastIdx (lastIdx),
    .cycReq  (cycReq),
    .cycType (cycType),
    .initDone(initDone)
  );

  vram_init_datapath #(
    .PAUSE_CYCLES(PAUSE_CYCLES),
    .PAUSE_W     (PauseW),
    .CNT_W       (CntW)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .lastIdx (lastIdx),
    .pauseEnd(pauseEnd),
    .cntLast (cntLast)
  );

endmodule

// File: tb/vram_bringup_seq_bench.sv
module vram_bringup_seq_bench;

  localparam int ClkPeriod = 10;
  localparam int Pause     = 20;
  localparam int PortCnt   = 8;
  localparam int SerCnt    = 2;
  localparam int PauseB    = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ack = 1'b0;
  logic req;
  logic [2:0] typ;
  logic done;

  logic rstB = 1'b1;
  logic ackB = 1'b0;
  logic reqB;
  logic [2:0] typB;
  logic doneB;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int logB[0:31];
  int nB = 0;

  always #(ClkPeriod/2) clk = ~clk;

  vram_bringup_seq #(.PAUSE_CYCLES(Pause), .PORT_INIT_COUNT(PortCnt),
                     .SERIAL_PULSES(SerCnt), .USE_CBR_INIT(1'b0)) u_vram_bringup_seq (
    .clk(clk), .rst(rst), .cycAck(ack), .cycReq(req), .cycType(typ), .initDone(done));

  vram_bringup_seq #(.PAUSE_CYCLES(PauseB), .PORT_INIT_COUNT(PortCnt),
                     .SERIAL_PULSES(SerCnt), .USE_CBR_INIT(1'b1)) u_vram_bringup_seq_cbr (
    .clk(clk), .rst(rstB), .cycAck(ackB), .cycReq(reqB), .cycType(typB), .initDone(doneB));

  always @(posedge clk) ackB <= rstB ? 1'b0 : reqB;

  always @(negedge clk) begin
    if (!rstB && reqB && nB < 32) begin
      logB[nB] = int'(typB);
      nB = nB + 1;
    end
  end

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (cycles > 20000) begin
      checks = checks + 1;
      fails  = fails + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic applyReset();
    @(negedge clk);
    rst = 1'b1;
    ack = 1'b0;
    repeat (3) @(negedge clk);
    check(!req && !done, "R1 outputs during reset", {req, done}, 0);
    rst = 1'b0;
  endtask

  // Called right after rst falls (at a negedge): checks the full pause length.
  task automatic checkPause(input int pulseAckAt);
    bit early = 1'b0;
    for (int i = 1; i <= Pause; i++) begin
      if (i == pulseAckAt) ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
      if (i == 1) check(!req && !done, "R1 first clock after reset", {req, done}, 0);
      if (i < Pause && req) early = 1'b1;
    end
    check(!early, "R2 no request during pause", early, 0);
    check(req == 1'b1, "R2 first request at pause end", req, 1);
  endtask

  task automatic serve(input int expT, input int dly, input string tag);
    int w = 0;
    while (!req && w < 100) begin
      @(negedge clk);
      w++;
    end
    check(req == 1'b1, {tag, " request present"}, req, 1);
    check(int'(typ) == expT, {tag, " cycle code"}, int'(typ), expT);
    @(negedge clk);
    check(!req, "R3 pulse is one clock", req, 0);
    for (int d = 0; d < dly; d++) begin
      @(negedge clk);
      check(!req, "R3 no request before ack", req, 0);
    end
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic testFullSequence();
    applyReset();
    checkPause(0);
    for (int k = 0; k < PortCnt; k++) serve(1, k % 3, "R4 row-only");
    serve(3, 2, "R5 transfer read");
    check(req == 1'b1, "R3 next request one clock after ack", req, 1);
    for (int k = 0; k < SerCnt; k++) serve(4, k, "R6 serial clock");
    check(!done, "R7 done low before stop ack", done, 0);
    serve(5, 1, "R7 stop-point set");
    check(done == 1'b1, "R8 done after stop ack", done, 1);
  endtask

  task automatic testDoneIgnoresAck();
    bit sawReq = 1'b0;
    bit lostDone = 1'b0;
    for (int k = 0; k < 6; k++) begin
      ack = (k % 2 == 0);
      @(negedge clk);
      if (req) sawReq = 1'b1;
      if (!done) lostDone = 1'b1;
    end
    ack = 1'b0;
    check(!sawReq, "R8 no request after done", sawReq, 0);
    check(!lostDone, "R8 done holds", lostDone, 0);
  endtask

  task automatic testStrayAcks();
    bit sawReq = 1'b0;
    applyReset();
    checkPause(5);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (req) sawReq = 1'b1;
    end
    check(!sawReq, "R9 ack with request pulse ignored", sawReq, 0);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    check(req == 1'b1 && int'(typ) == 1, "R9 real ack advances", int'(typ), 1);
    for (int k = 1; k < PortCnt; k++) serve(1, 0, "R9 row-only count");
    serve(3, 0, "R9 order kept");
  endtask

  task automatic testMidReset();
    applyReset();
    checkPause(0);
    serve(1, 0, "R10 before reset");
    serve(1, 0, "R10 before reset");
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(!req && !done, "R10 reset clears outputs", {req, done}, 0);
    rst = 1'b0;
    checkPause(0);
    for (int k = 0; k < PortCnt; k++) serve(1, 0, "R10 restarted port phase");
    serve(3, 0, "R10 restarted transfer");
  endtask

  task automatic testCbrVariant();
    int w = 0;
    @(negedge clk);
    rstB = 1'b0;
    while (!doneB && w < 500) begin
      @(negedge clk);
      w++;
    end
    check(doneB == 1'b1, "R8 refresh-style variant done", doneB, 1);
    check(nB == PortCnt + 1 + SerCnt + 1, "R4 refresh-style request count", nB, PortCnt + SerCnt + 2);
    for (int k = 0; k < PortCnt; k++)
      check(logB[k] == 2, "R4 CAS-before-RAS code", logB[k], 2);
    check(logB[PortCnt] == 3, "R5 transfer after refresh-style run", logB[PortCnt], 3);
    check(logB[PortCnt + 1] == 4 && logB[PortCnt + 2] == 4, "R6 serial pulses", logB[PortCnt + 1], 4);
    check(logB[PortCnt + 3] == 5, "R7 stop-point set last", logB[PortCnt + 3], 5);
  endtask

  initial begin
    testFullSequence();
    testDoneIgnoresAck();
    testStrayAcks();
    testMidReset();
    testCbrVariant();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule